// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is an on-chip static memory with a fully synchronous, pipelined port. Each rising clock edge can start a read, a write or nothing. Reads and writes can follow each other in any order with no idle bus cycle between them. A read returns its data two effective clock edges after its address. A write takes its data from the data bus two effective edges after its address. Because both directions use the same latency, the shared bus never needs a turnaround gap. The storage is 36 bits wide and split into four 9-bit byte lanes. Its depth is set by a parameter.

Three chip enables, two active low and one active high, let several of these memories share one address bus without contention. A load cycle starts a new operation. An advance cycle steps a four-beat burst on the two lowest address bits, in linear or interleaved order chosen by a static mode pin. A clock enable freezes the whole pipeline. An asynchronous output enable and an asynchronous sleep input gate the read data outputs. The bidirectional pad is modelled as separate data-in, data-out and output-valid ports.

A read aimed at an address whose write has not yet been committed returns the newer data, merged per byte lane. Back-to-back write-then-read sequences therefore stay coherent.

Top module: `nt_sram`

## Requirements
- R1: While `rst_n` is low and after it rises, no operation is pending, and `dout_vld` is 0 with `dout` all zeros until a read completes.
- R2: A read loaded at effective edge k drives its word on `dout` with `dout_vld`=1 after effective edge k+2. The word stays there until the next effective edge. An effective edge is one with `clk_en`=1 and `sleep`=0. Completing writes and idle slots give `dout_vld`=0.
- R3: A write loaded at effective edge k stores `din` as sampled at effective edge k+2. Only lane i, bits [9i+8:9i], is written, and only when `byte_we[i]` was 1 at edge k.
- R4: Reads and writes may be issued on consecutive edges in any mix. A read returns every write issued before it, merged per byte lane, even when that write has not yet been committed to the array.
- R5: An edge with `clk_en`=0 has no effect: no operation is loaded, nothing is written, and `dout` and the burst state are held.
- R6: A load cycle (`adv_ld`=0) starts an operation only when `ce0`=1, `ce1_n`=0 and `ce2_n`=0. Otherwise the slot is idle: no write happens and no read data appears for it.
- R7: An advance cycle (`adv_ld`=1) with `mode_ilv`=0 repeats the previous operation's type at the address whose two low bits are (start + beat) mod 4. The beat counts 1, 2, 3, 0 and so on, and the upper bits are kept.
- R8: An advance cycle with `mode_ilv`=1 uses low address bits equal to start XOR beat.
- R9: `oe_n`=1 forces `dout_vld` to 0 and `dout` to zero at once, with no clock edge.
- R10: `sleep`=1 forces `dout_vld` to 0 at once. Edges with `sleep`=1 hold all state as in R5, and the stored contents are kept.
- R11: An advance cycle that follows an idle slot (deselected load or reset) stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en | input | 1 | Clock enable; 0 suspends the block |
| ce0 | input | 1 | Chip enable, active high |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| we | input | 1 | Cycle type on load: 1 write, 0 read |
| adv_ld | input | 1 | 1 advances the burst, 0 loads a new address |
| byte_we | input | LANES | Per-lane write enables, bit i for lane i |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, taken two effective edges after the address |
| mode_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down |
| dout | output | LANES*LANE_W | Read data; zero when not valid |
| dout_vld | output | 1 | Read data is being driven |

## Verification
The assertions assume that `mode_ilv` is held steady while a burst is running. They also assume that `sleep` and `oe_n` are only meaningful as levels, with no glitches inside a clock period. The stimulus changes the burst mode only after several deselected load cycles have drained the pipeline. It changes `oe_n` and `sleep` only at the falling clock edge or in short gaps away from the rising edge. Reads go only to addresses that an earlier full-mask write has initialised, so the merged byte lanes are never undefined.

// File: rtl/nt_sram_pkg.sv
`timescale 1ns/1ps
package nt_sram_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    // low address bits of a burst beat
    function automatic logic [BEAT_W-1:0] burst_low(
        input logic              ilv,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/nt_sram_seq.sv
`timescale 1ns/1ps
module nt_sram_seq
    import nt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              adv_ld,
    input  logic              we,
    input  logic              ce0,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    input  op_kind_e          cur_kind,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [BEAT_W-1:0] cur_start,
    input  logic [BEAT_W-1:0] cur_beat,
    output op_kind_e          nxt_kind,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [BEAT_W-1:0] nxt_start,
    output logic [BEAT_W-1:0] nxt_beat
);

    logic              chip_sel;
    logic [BEAT_W-1:0] beat_inc;

    always_comb begin
        chip_sel  = ce0 & ~ce1_n & ~ce2_n;
        beat_inc  = cur_beat + BEAT_W'(1);
        nxt_kind  = OP_IDLE;
        nxt_addr  = cur_addr;
        nxt_start = cur_start;
        nxt_beat  = cur_beat;
        if (!adv_ld) begin
            if (chip_sel) begin
                nxt_kind  = we ? OP_WRITE : OP_READ;
                nxt_addr  = addr_in;
                nxt_start = addr_in[BEAT_W-1:0];
                nxt_beat  = '0;
            end
        end else if (cur_kind != OP_IDLE) begin
            nxt_kind = cur_kind;
            nxt_beat = beat_inc;
            nxt_addr = {cur_addr[ADDR_W-1:BEAT_W],
                        burst_low(mode_ilv, cur_start, beat_inc)};
        end
    end

endmodule

// File: rtl/nt_sram_array.sv
`timescale 1ns/1ps
module nt_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wbe,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wbe[l]) begin
                bank[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/nt_sram_merge.sv
`timescale 1ns/1ps
module nt_sram_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    hit,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [LANES*LANE_W-1:0] new_data,
    input  logic [LANES*LANE_W-1:0] old_data,
    output logic [LANES*LANE_W-1:0] merged
);

    for (genvar l = 0; l < LANES; l++) begin : g_mux
        assign merged[l*LANE_W +: LANE_W] = (hit && lane_sel[l])
            ? new_data[l*LANE_W +: LANE_W]
            : old_data[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/nt_sram.sv
`timescale 1ns/1ps
module nt_sram
    import nt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    ce0,
    input  logic                    ce1_n,
    input  logic                    ce2_n,
    input  logic                    we,
    input  logic                    adv_ld,
    input  logic [LANES-1:0]        byte_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    mode_ilv,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_kind_e          s1_kind;
        logic [ADDR_W-1:0] s1_addr;
        logic [BEAT_W-1:0] s1_start;
        logic [BEAT_W-1:0] s1_beat;
        logic [LANES-1:0]  s1_be;
        op_kind_e          s2_kind;
        logic [ADDR_W-1:0] s2_addr;
        logic [LANES-1:0]  s2_be;
        logic [DATA_W-1:0] s2_rdata;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
    } state_t;

    state_t st_d, st_q;

    logic              step;
    logic              wr_commit;
    logic              fwd_hit;
    op_kind_e          nxt_kind;
    logic [ADDR_W-1:0] nxt_addr;
    logic [BEAT_W-1:0] nxt_start;
    logic [BEAT_W-1:0] nxt_beat;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] fwd_data;

    assign step      = clk_en & ~sleep;
    assign wr_commit = step && (st_q.s2_kind == OP_WRITE);
    assign fwd_hit   = (st_q.s2_kind == OP_WRITE) && (st_q.s2_addr == st_q.s1_addr);

    nt_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .adv_ld    (adv_ld),
        .we        (we),
        .ce0       (ce0),
        .ce1_n     (ce1_n),
        .ce2_n     (ce2_n),
        .mode_ilv  (mode_ilv),
        .addr_in   (addr),
        .cur_kind  (st_q.s1_kind),
        .cur_addr  (st_q.s1_addr),
        .cur_start (st_q.s1_start),
        .cur_beat  (st_q.s1_beat),
        .nxt_kind  (nxt_kind),
        .nxt_addr  (nxt_addr),
        .nxt_start (nxt_start),
        .nxt_beat  (nxt_beat)
    );

    nt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .wr_en (wr_commit),
        .waddr (st_q.s2_addr),
        .wbe   (st_q.s2_be),
        .wdata (din),
        .raddr (st_q.s1_addr),
        .rdata (arr_rdata)
    );

    nt_sram_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .hit      (fwd_hit),
        .lane_sel (st_q.s2_be),
        .new_data (din),
        .old_data (arr_rdata),
        .merged   (fwd_data)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.s1_kind  = nxt_kind;
            st_d.s1_addr  = nxt_addr;
            st_d.s1_start = nxt_start;
            st_d.s1_beat  = nxt_beat;
            st_d.s1_be    = byte_we;
            st_d.s2_kind  = st_q.s1_kind;
            st_d.s2_addr  = st_q.s1_addr;
            st_d.s2_be    = st_q.s1_be;
            if (st_q.s1_kind == OP_READ) begin
                st_d.s2_rdata = fwd_data;
            end
            st_d.out_vld = (st_q.s2_kind == OP_READ);
            if (st_q.s2_kind == OP_READ) begin
                st_d.out_data = st_q.s2_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_vld = st_q.out_vld & ~oe_n & ~sleep;
    assign dout     = dout_vld ? st_q.out_data : '0;

endmodule

// File: rtl/nt_sram_chk.sv
`timescale 1ns/1ps
module nt_sram_chk
    import nt_sram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              sleep,
    input logic              oe_n,
    input logic              adv_ld,
    input logic              ce0,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              mode_ilv,
    input logic              dout_vld,
    input op_kind_e          s1_kind,
    input logic [BEAT_W-1:0] s1_low,
    input logic [BEAT_W-1:0] s1_start,
    input logic [BEAT_W-1:0] s1_beat,
    input op_kind_e          s2_kind,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_data
);

    logic live;
    assign live = clk_en & ~sleep;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (live && s2_kind == OP_READ) |=> out_vld); // R2

    AST_NONREAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (live && s2_kind != OP_READ) |=> !out_vld); // R2

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> ($stable(out_data) && $stable(out_vld) && $stable(s1_low) && $stable(s1_kind))); // R5

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !adv_ld && !(ce0 && !ce1_n && !ce2_n)) |=> (s1_kind == OP_IDLE)); // R6

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && adv_ld && s1_kind != OP_IDLE && !mode_ilv) |=> (s1_low == $past(s1_low) + BEAT_W'(1))); // R7

    AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && adv_ld && s1_kind != OP_IDLE && mode_ilv) |=> ((s1_low ^ s1_start) == s1_beat)); // R8

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_vld); // R9

    AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_vld); // R10

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(s1_kind) && $stable(out_vld))); // R10

    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && adv_ld && s1_kind == OP_IDLE) |=> (s1_kind == OP_IDLE)); // R11

endmodule

bind nt_sram nt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sleep    (sleep),
    .oe_n     (oe_n),
    .adv_ld   (adv_ld),
    .ce0      (ce0),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .mode_ilv (mode_ilv),
    .dout_vld (dout_vld),
    .s1_kind  (st_q.s1_kind),
    .s1_low   (st_q.s1_addr[1:0]),
    .s1_start (st_q.s1_start),
    .s1_beat  (st_q.s1_beat),
    .s2_kind  (st_q.s2_kind),
    .out_vld  (st_q.out_vld),
    .out_data (st_q.out_data)
);

// File: tb/sim_nt_sram.sv
`timescale 1ns/1ps
module sim_nt_sram;

    localparam int AW    = 8;
    localparam int NL    = 4;
    localparam int LW    = 9;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;
    localparam int K_IDLE = 0;
    localparam int K_RD   = 1;
    localparam int K_WR   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          ce0 = 1'b0;
    logic          ce1_n = 1'b1;
    logic          ce2_n = 1'b1;
    logic          we = 1'b0;
    logic          adv_ld = 1'b0;
    logic [NL-1:0] byte_we = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          mode_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_vld;

    always #2 clk = ~clk;

    nt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce0(ce0), .ce1_n(ce1_n),
        .ce2_n(ce2_n), .we(we), .adv_ld(adv_ld), .byte_we(byte_we), .addr(addr),
        .din(din), .mode_ilv(mode_ilv), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_vld(dout_vld)
    );

    typedef struct {
        int       kind;
        int       adr;
        bit [3:0] be;
    } ent_t;

    int          checks = 0;
    int          fails  = 0;
    string       cur_req = "R1";
    logic [DW-1:0] mmem [DEPTH];
    ent_t        pq[$];
    bit          exp_v = 0;
    logic [DW-1:0] exp_d = '0;
    bit          b_act = 0;
    int          b_kind = 0;
    int          b_base = 0;
    int          b_n = 0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        ent_t z;
        z.kind = K_IDLE; z.adr = 0; z.be = 4'h0;
        pq.delete();
        pq.push_back(z);
        pq.push_back(z);
        exp_v = 0;
        b_act = 0;
    endtask

    task automatic model_step();
        ent_t old;
        ent_t nw;
        int   st;
        int   lo;
        old = pq.pop_front();
        exp_v = 0;
        if (old.kind == K_WR) begin
            for (int l = 0; l < NL; l++) begin
                if (old.be[l]) mmem[old.adr][l*LW +: LW] = din[l*LW +: LW];
            end
        end else if (old.kind == K_RD) begin
            exp_v = 1;
            exp_d = mmem[old.adr];
        end
        nw.kind = K_IDLE; nw.adr = 0; nw.be = byte_we;
        if (!adv_ld) begin
            if (ce0 && !ce1_n && !ce2_n) begin
                b_act = 1; b_kind = we ? K_WR : K_RD; b_base = int'(addr); b_n = 0;
                nw.kind = b_kind; nw.adr = b_base;
            end else begin
                b_act = 0;
            end
        end else if (b_act) begin
            b_n = (b_n + 1) % 4;
            st  = b_base % 4;
            lo  = mode_ilv ? (st ^ b_n) : ((st + b_n) % 4);
            nw.kind = b_kind;
            nw.adr  = b_base - st + lo;
        end
        pq.push_back(nw);
    endtask

    task automatic compare();
        bit ev;
        ev = exp_v && !oe_n && !sleep;
        check(dout_vld == ev, cur_req, DW'(dout_vld), DW'(ev));
        if (ev) check(dout == exp_d, cur_req, dout, exp_d);
        else    check(dout == '0, cur_req, dout, '0);
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n && clk_en && !sleep) model_step();
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic drive(input bit al, input bit w, input int a, input bit [3:0] be, input bit [2:0] sel);
        adv_ld  = al;
        we      = w;
        addr    = AW'(a);
        byte_we = be;
        ce0     = sel[0];
        ce1_n   = ~sel[1];
        ce2_n   = ~sel[2];
        din     = {4'($urandom), 32'($urandom)};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 4'h0, 3'b000);
            tick();
        end
    endtask

    task automatic burst_phase(input int n);
        for (int b = 0; b < n; b++) begin
            drive(0, 1'($urandom), $urandom_range(0, 31), 4'($urandom), 3'b111);
            tick();
            for (int k = 0; k < $urandom_range(2, 6); k++) begin
                drive(1, 1'($urandom), $urandom_range(0, 255), 4'($urandom), 3'($urandom));
                tick();
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        drive(0, 1, 5, 4'hF, 3'b111);
        @(negedge clk);
        check(dout_vld == 1'b0, "R1", DW'(dout_vld), '0);
        check(dout == '0, "R1", dout, '0);
        model_reset();
        rst_n = 1'b1;
        idle(1);
        check(dout_vld == 1'b0, "R1", DW'(dout_vld), '0);

        // R3: full-mask writes initialise every word
        cur_req = "R3";
        for (int a = 0; a < DEPTH; a++) begin
            drive(0, 1, a, 4'hF, 3'b111);
            tick();
        end
        // R3: partial-lane writes
        for (int i = 0; i < 40; i++) begin
            drive(0, 1, $urandom_range(0, 15), 4'($urandom), 3'b111);
            tick();
        end

        // R2: read latency
        cur_req = "R2";
        for (int i = 0; i < 30; i++) begin
            drive(0, 0, $urandom_range(0, 255), 4'h0, 3'b111);
            tick();
        end

        // R4: back-to-back mixed traffic on few addresses
        cur_req = "R4";
        for (int i = 0; i < 80; i++) begin
            drive(0, 1'($urandom), $urandom_range(0, 3), 4'($urandom), 3'b111);
            tick();
        end

        // R5: clock-enable suspend
        cur_req = "R5";
        for (int i = 0; i < 100; i++) begin
            clk_en = ($urandom_range(0, 2) != 0);
            drive(0, 1'($urandom), $urandom_range(0, 7), 4'($urandom), 3'b111);
            tick();
        end
        clk_en = 1'b1;

        // R6: chip-enable decoding
        cur_req = "R6";
        for (int i = 0; i < 100; i++) begin
            drive(0, 1'($urandom), $urandom_range(0, 15), 4'($urandom), 3'($urandom));
            tick();
        end
        for (int a = 0; a < 16; a++) begin
            drive(0, 0, a, 4'h0, 3'b111);
            tick();
        end

        // R7: linear bursts
        idle(3);
        cur_req = "R7";
        mode_ilv = 1'b0;
        burst_phase(25);

        // R8: interleaved bursts
        idle(3);
        cur_req = "R8";
        mode_ilv = 1'b1;
        burst_phase(25);

        // R11: advance after idle slots
        idle(3);
        cur_req = "R11";
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 1) == 0) drive(0, 1'($urandom), $urandom_range(0, 31), 4'($urandom), 3'($urandom));
            else                           drive(1, 0, 0, 4'($urandom), 3'($urandom));
            tick();
        end

        // R9: asynchronous output enable
        cur_req = "R9";
        for (int i = 0; i < 60; i++) begin
            oe_n = ($urandom_range(0, 3) == 0);
            drive(0, 1'($urandom), $urandom_range(0, 15), 4'($urandom), 3'b111);
            tick();
            if (exp_v && !oe_n) begin
                oe_n = 1'b1;
                #0.5;
                check(dout_vld == 1'b0, "R9", DW'(dout_vld), '0);
                check(dout == '0, "R9", dout, '0);
                oe_n = 1'b0;
                #0.5;
                check(dout_vld == 1'b1, "R9", DW'(dout_vld), DW'(1));
                check(dout == exp_d, "R9", dout, exp_d);
            end
        end
        oe_n = 1'b0;

        // R10: sleep gating and hold
        cur_req = "R10";
        for (int i = 0; i < 80; i++) begin
            sleep = ($urandom_range(0, 4) == 0);
            drive(0, 1'($urandom), $urandom_range(0, 15), 4'($urandom), 3'b111);
            tick();
            if (exp_v && !sleep) begin
                sleep = 1'b1;
                #0.5;
                check(dout_vld == 1'b0, "R10", DW'(dout_vld), '0);
                sleep = 1'b0;
                #0.5;
                check(dout == exp_d, "R10", dout, exp_d);
            end
        end
        sleep = 1'b0;

        // R4: mixed traffic with bursts and suspends
        cur_req = "R4";
        for (int i = 0; i < 300; i++) begin
            clk_en = ($urandom_range(0, 5) != 0);
            drive(1'($urandom), 1'($urandom), $urandom_range(0, 31), 4'($urandom),
                  ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b111);
            tick();
        end
        clk_en = 1'b1;
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule